// File: doc/BRIEF.md
# Prioritized Exception Request Controller

This block gathers the asynchronous exception sources of a processor core and presents one registered request, with the code of the winning source, to the core. The sources are four maskable interrupt lines, two trap lines and one active-low warning line. Every input crosses into the system clock domain through its own synchronizer before any priority decision is made.

The interrupt lines are gated by a priority level rather than by individual enable bits. A single disable input turns off both trap lines. A falling edge on the warning line is captured and held. This warning request cannot be masked and carries a flag that tells the core to skip its normal vector fetch. Interrupt and trap requests are levels and are looked at again on every cycle. The captured warning is removed only when the core acknowledges it.

Top module: `exc_req_ctl`

## Requirements
- R1: An interrupt or trap input change first shows at the outputs 3 clock edges after it is applied (two synchronizer flops plus the output register). A warning falling edge shows after 4 edges.
- R2: Among the enabled interrupt lines, the lowest index wins. Interrupt line i is reported as code 3+i.
- R3: A mask level of N (mask_level_i) enables interrupt lines 0 through N. Lines above N never raise exc_req_o.
- R4: Traps outrank every interrupt, and trap 0 outranks trap 1. Trap t is reported as code 1+t.
- R5: While trap_disable_i is 1, neither trap line raises a request, whatever its level.
- R6: A falling edge on warn_n_i raises a request with code 0 and exc_skip_vec_o at 1. This request beats every trap and interrupt and ignores the mask level and the trap disable.
- R7: A captured warning stays requested after warn_n_i returns high. It ends only when ack_i is asserted while the warning is the presented request.
- R8: A falling edge on warn_n_i is ignored unless the synchronized line was high for at least 4 consecutive cycles before that edge.
- R9: ack_i drops exc_req_o and exc_skip_vec_o on the next clock edge. Level requests that are still active are presented again one edge later.
- R10: After reset, exc_req_o, exc_code_o and exc_skip_vec_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req_i | input | 4 | Asynchronous interrupt request levels, active high |
| trap_req_i | input | 2 | Asynchronous trap request levels, active high |
| warn_n_i | input | 1 | Asynchronous warning line, falling-edge sensitive |
| mask_level_i | input | 2 | Highest interrupt line that is allowed through |
| trap_disable_i | input | 1 | Blocks both trap lines when 1 |
| ack_i | input | 1 | Core acknowledge of the presented request |
| exc_req_o | output | 1 | A request is being presented |
| exc_code_o | output | 3 | Winning source: 0 warning, 1-2 traps, 3-6 interrupts |
| exc_skip_vec_o | output | 1 | The presented request must skip the vector fetch |

## Verification
The assertions check on every cycle that the outputs are consistent with each other and with the control inputs:
- A presented interrupt code never lies above the mask level of the previous cycle.
- No trap code appears after a cycle with the trap disable set.
- The skip flag goes with code 0 and with nothing else.
- An acknowledge always removes the request on the following edge.
- No code lies outside the defined range.

Several behaviours can only be shown by the bench's directed scenarios, because each one depends on the history of the asynchronous inputs: the exact synchronizer latency, priority order between live sources, the holding of a captured warning after its line returns high, and the rejection of a warning edge that follows a short high pulse.

// File: rtl/exc_req_pkg.sv
// Package: shared code-numbering helpers for the exception request controller.
// Assumes source code 0 is the warning, then traps, then interrupts.
package exc_req_pkg;

    // Code reserved for the non-maskable warning source.
    localparam int unsigned WARN_CODE = 0;

    // Code reported for trap line t.
    function automatic int unsigned trap_code(input int unsigned t);
        return 1 + t;
    endfunction

    // Code reported for interrupt line i, given the number of trap lines.
    function automatic int unsigned irq_code(input int unsigned i, input int unsigned ntrap);
        return 1 + ntrap + i;
    endfunction

endpackage

// File: rtl/exc_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous levels.
// Assumes each bit is an independent level; no bus coherency is implied.
module exc_sync #(
    parameter int unsigned WIDTH     = 1,
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RESET_VAL}};

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (s == 0) begin : g_first
            // First stage: capture the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VEC;
                else        q <= async_in;
            end
        end else begin : g_next
            // Later stages: pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VEC;
                else        q <= g_stage[s-1].q;
            end
        end
    end

    assign sync_out = g_stage[STAGES-1].q;

endmodule

// File: rtl/exc_warn_edge.sv
// Module: falling-edge catcher for the synchronized warning line.
// An edge is accepted only after the line was high for HOLD consecutive
// cycles; the captured request is held until the clear input is asserted.
// Assumes warn_lvl is already synchronized (1 = line high).
module exc_warn_edge #(
    parameter int unsigned HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_lvl,
    input  logic clear,
    output logic pending
);

    localparam int unsigned CNTW = $clog2(HOLD + 1);

    logic            prev_q;
    logic [CNTW-1:0] high_cnt_q;
    logic            fall_ok;

    // Qualified falling edge: high before, low now, and high long enough.
    assign fall_ok = prev_q && !warn_lvl && (high_cnt_q >= CNTW'(HOLD));

    // Track the previous level and count consecutive high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= 1'b1;
            high_cnt_q <= '0;
        end else begin
            prev_q <= warn_lvl;
            if (!warn_lvl)
                high_cnt_q <= '0;
            else if (high_cnt_q < CNTW'(HOLD))
                high_cnt_q <= high_cnt_q + 1'b1;
        end
    end

    // Hold the warning request; a new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (fall_ok) pending <= 1'b1;
        else if (clear)   pending <= 1'b0;
    end

endmodule

// File: rtl/exc_prio_arb.sv
// Module: combinational priority selection across warning, traps and
// interrupts. Priority: warning, trap 0..NT-1, interrupt 0..NI-1.
// Assumes all request inputs are synchronous to the clock.
module exc_prio_arb
    import exc_req_pkg::*;
#(
    parameter int unsigned NUM_IRQ  = 4,
    parameter int unsigned NUM_TRAP = 2,
    parameter int unsigned CW       = 3,
    parameter int unsigned MW       = 2
) (
    input  logic                warn_pend,
    input  logic [NUM_TRAP-1:0] trap_lvl,
    input  logic                trap_disable,
    input  logic [NUM_IRQ-1:0]  irq_lvl,
    input  logic [MW-1:0]       mask_level,
    output logic                any_req,
    output logic [CW-1:0]       win_code,
    output logic                win_skip
);

    logic [NUM_IRQ-1:0] irq_en;

    // A line is enabled when its index does not exceed the mask level.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq_en
        assign irq_en[g] = (mask_level >= MW'(g));
    end

    // Scan from lowest to highest priority so the highest one is kept.
    always_comb begin
        any_req  = 1'b0;
        win_code = '0;
        win_skip = 1'b0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (irq_lvl[i] && irq_en[i]) begin
                any_req  = 1'b1;
                win_code = CW'(irq_code(i, NUM_TRAP));
            end
        end
        for (int t = NUM_TRAP - 1; t >= 0; t--) begin
            if (trap_lvl[t] && !trap_disable) begin
                any_req  = 1'b1;
                win_code = CW'(trap_code(t));
            end
        end
        if (warn_pend) begin
            any_req  = 1'b1;
            win_code = CW'(WARN_CODE);
            win_skip = 1'b1;
        end
    end

endmodule

// File: rtl/exc_req_ctl.sv
// Module: top of the prioritized exception request controller.
// Synchronizes interrupt, trap and warning inputs, selects one winner and
// presents it in a registered request that the core's acknowledge drops.
// Assumes mask_level_i, trap_disable_i and ack_i are synchronous to clk.
module exc_req_ctl
    import exc_req_pkg::*;
#(
    parameter int unsigned NUM_IRQ     = 4,
    parameter int unsigned NUM_TRAP    = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WARN_HOLD   = 4,
    localparam int unsigned NUM_SRC    = 1 + NUM_TRAP + NUM_IRQ,
    localparam int unsigned CW         = $clog2(NUM_SRC),
    localparam int unsigned MW         = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_req_i,
    input  logic [NUM_TRAP-1:0] trap_req_i,
    input  logic                warn_n_i,
    input  logic [MW-1:0]       mask_level_i,
    input  logic                trap_disable_i,
    input  logic                ack_i,
    output logic                exc_req_o,
    output logic [CW-1:0]       exc_code_o,
    output logic                exc_skip_vec_o
);

    logic [NUM_IRQ-1:0]  irq_sync;
    logic [NUM_TRAP-1:0] trap_sync;
    logic                warn_sync;
    logic                warn_pend;
    logic                warn_clear;
    logic                any_req;
    logic [CW-1:0]       win_code;
    logic                win_skip;

    exc_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_irq_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_req_i),
        .sync_out (irq_sync)
    );

    exc_sync #(.WIDTH(NUM_TRAP), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_trap_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trap_req_i),
        .sync_out (trap_sync)
    );

    exc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_warn_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (warn_n_i),
        .sync_out (warn_sync)
    );

    // The warning is released only when the core acknowledges it as presented.
    assign warn_clear = ack_i && exc_req_o && exc_skip_vec_o;

    exc_warn_edge #(.HOLD(WARN_HOLD)) u_warn_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .warn_lvl (warn_sync),
        .clear    (warn_clear),
        .pending  (warn_pend)
    );

    exc_prio_arb #(
        .NUM_IRQ  (NUM_IRQ),
        .NUM_TRAP (NUM_TRAP),
        .CW       (CW),
        .MW       (MW)
    ) u_arb (
        .warn_pend    (warn_pend),
        .trap_lvl     (trap_sync),
        .trap_disable (trap_disable_i),
        .irq_lvl      (irq_sync),
        .mask_level   (mask_level_i),
        .any_req      (any_req),
        .win_code     (win_code),
        .win_skip     (win_skip)
    );

    // Output register: drop on acknowledge, otherwise follow the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_req_o      <= 1'b0;
            exc_code_o     <= '0;
            exc_skip_vec_o <= 1'b0;
        end else if (ack_i) begin
            exc_req_o      <= 1'b0;
            exc_skip_vec_o <= 1'b0;
        end else begin
            exc_req_o      <= any_req;
            exc_code_o     <= win_code;
            exc_skip_vec_o <= win_skip;
        end
    end

endmodule

// File: rtl/exc_req_ctl_chk.sv
// Module: protocol checker for exc_req_ctl, attached with a bind.
// Assumes the code numbering of exc_req_pkg.
module exc_req_ctl_chk #(
    parameter int unsigned NUM_IRQ  = 4,
    parameter int unsigned NUM_TRAP = 2,
    parameter int unsigned CW       = 3,
    parameter int unsigned MW       = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [MW-1:0] mask_level_i,
    input logic          trap_disable_i,
    input logic          ack_i,
    input logic          exc_req_o,
    input logic [CW-1:0] exc_code_o,
    input logic          exc_skip_vec_o
);

    // R3
    mask_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_o && int'(exc_code_o) >= 1 + NUM_TRAP)
            |-> (int'(exc_code_o) - 1 - NUM_TRAP) <= int'($past(mask_level_i)));

    // R5
    trap_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_o && exc_code_o != '0 && int'(exc_code_o) <= NUM_TRAP)
            |-> !$past(trap_disable_i));

    // R6
    skip_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_skip_vec_o |-> (exc_req_o && exc_code_o == '0));

    // R6
    warn_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_o && exc_code_o == '0) |-> exc_skip_vec_o);

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (!exc_req_o && !exc_skip_vec_o));

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> int'(exc_code_o) <= NUM_IRQ + NUM_TRAP);

endmodule

bind exc_req_ctl exc_req_ctl_chk #(
    .NUM_IRQ  (NUM_IRQ),
    .NUM_TRAP (NUM_TRAP),
    .CW       (CW),
    .MW       (MW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mask_level_i   (mask_level_i),
    .trap_disable_i (trap_disable_i),
    .ack_i          (ack_i),
    .exc_req_o      (exc_req_o),
    .exc_code_o     (exc_code_o),
    .exc_skip_vec_o (exc_skip_vec_o)
);

// File: tb/exc_req_ctl_bench.sv
// Directed bench for exc_req_ctl: one task per scenario, each self-checking.
module exc_req_ctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irq = '0;
    logic [1:0] trap = '0;
    logic       warn_n = 1'b1;
    logic [1:0] mask = 2'd3;
    logic       tdis = 1'b0;
    logic       ack = 1'b0;
    logic       req;
    logic [2:0] code;
    logic       skip;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    exc_req_ctl u_exc_req_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_req_i      (irq),
        .trap_req_i     (trap),
        .warn_n_i       (warn_n),
        .mask_level_i   (mask),
        .trap_disable_i (tdis),
        .ack_i          (ack),
        .exc_req_o      (req),
        .exc_code_o     (code),
        .exc_skip_vec_o (skip)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare {req, code, skip} against the expected value.
    task automatic chk(input string tag, input logic r, input logic [2:0] c, input logic s);
        n_checks++;
        if ({req, code, skip} !== {r, c, s}) begin
            n_fail++;
            $display("FAIL %s: got req=%0b code=%0d skip=%0b, expected req=%0b code=%0d skip=%0b",
                     tag, req, code, skip, r, c, s);
        end
    endtask

    // Compare the request flag only.
    task automatic chk_req(input string tag, input logic r);
        n_checks++;
        if (req !== r) begin
            n_fail++;
            $display("FAIL %s: got req=%0b, expected req=%0b", tag, req, r);
        end
    endtask

    task automatic t_reset();
        chk("R10 reset state", 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_latency();
        irq = 4'b0100; mask = 2'd3;
        step(2); chk_req("R1 not yet visible after 2 edges", 1'b0);
        step(1); chk("R1 visible after 3 edges", 1'b1, 3'd5, 1'b0);
        irq = '0; step(3); chk_req("R1 release after 3 edges", 1'b0);
    endtask

    task automatic t_irq_prio();
        mask = 2'd3;
        irq = 4'b1110; step(3); chk("R2 line1 over 2,3", 1'b1, 3'd4, 1'b0);
        irq = 4'b1111; step(3); chk("R2 line0 over all", 1'b1, 3'd3, 1'b0);
        irq = 4'b1000; step(3); chk("R2 line3 alone", 1'b1, 3'd6, 1'b0);
        irq = '0; step(3);
    endtask

    task automatic t_mask();
        irq = 4'b1111; mask = 2'd0; step(3); chk("R3 level0 passes line0", 1'b1, 3'd3, 1'b0);
        irq = 4'b1110; step(3); chk_req("R3 level0 blocks lines 1-3", 1'b0);
        mask = 2'd1; step(3); chk("R3 level1 passes line1", 1'b1, 3'd4, 1'b0);
        irq = 4'b1000; mask = 2'd2; step(3); chk_req("R3 level2 blocks line3", 1'b0);
        mask = 2'd3; step(3); chk("R3 level3 passes line3", 1'b1, 3'd6, 1'b0);
        irq = '0; step(3);
    endtask

    task automatic t_trap();
        irq = 4'b1111; trap = 2'b11; step(3); chk("R4 trap0 over all", 1'b1, 3'd1, 1'b0);
        trap = 2'b10; step(3); chk("R4 trap1 over interrupts", 1'b1, 3'd2, 1'b0);
        irq = '0; trap = '0; step(3);
    endtask

    task automatic t_trap_dis();
        trap = 2'b11; tdis = 1'b1; step(3); chk_req("R5 traps disabled", 1'b0);
        irq = 4'b0100; step(3); chk("R5 interrupt wins while traps off", 1'b1, 3'd5, 1'b0);
        tdis = 1'b0; step(3); chk("R5 traps back on", 1'b1, 3'd1, 1'b0);
        trap = '0; irq = '0; step(3);
    endtask

    task automatic t_warn();
        trap = 2'b01; irq = 4'b1111; tdis = 1'b1; mask = 2'd0; step(3);
        warn_n = 1'b0;
        step(3); chk("R1 warning not yet visible after 3 edges", 1'b1, 3'd3, 1'b0);
        step(1); chk("R6 warning wins, skip set", 1'b1, 3'd0, 1'b1);
        warn_n = 1'b1; step(5); chk("R7 warning held after release", 1'b1, 3'd0, 1'b1);
        tdis = 1'b0; step(2); chk("R7 still held without ack", 1'b1, 3'd0, 1'b1);
        ack = 1'b1; step(1); ack = 1'b0;
        chk("R9 ack drops request", 1'b0, 3'd0, 1'b0);
        step(1); chk("R9 level trap re-presented, R7 warning cleared", 1'b1, 3'd1, 1'b0);
        trap = '0; irq = '0; mask = 2'd3; step(3);
    endtask

    task automatic t_rearm();
        step(6);
        warn_n = 1'b0; step(4); chk("R6 warning captured", 1'b1, 3'd0, 1'b1);
        ack = 1'b1; step(1); ack = 1'b0; step(1);
        chk_req("R9 warning acked", 1'b0);
        warn_n = 1'b1; step(2); warn_n = 1'b0;
        step(6); chk_req("R8 short high pulse ignored", 1'b0);
        warn_n = 1'b1; step(6); warn_n = 1'b0;
        step(4); chk("R8 edge after long high accepted", 1'b1, 3'd0, 1'b1);
        ack = 1'b1; step(1); ack = 1'b0; step(1);
        warn_n = 1'b1; step(6);
    endtask

    task automatic t_ack_level();
        irq = 4'b0001; step(3); chk("R9 level present", 1'b1, 3'd3, 1'b0);
        ack = 1'b1; step(1); ack = 1'b0;
        chk_req("R9 dropped on ack", 1'b0);
        step(1); chk("R9 level re-presented", 1'b1, 3'd3, 1'b0);
        irq = '0; step(3);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        step(6);
        t_latency();
        t_irq_prio();
        t_mask();
        t_trap();
        t_trap_dis();
        t_warn();
        t_rearm();
        t_ack_level();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule